// File: doc/BRIEF.md
# DRAM Strobe Decoder with Parallel Test Mode

This block is a clocked behavioural model of the control side of a multiplexed-address DRAM, for use in testbenches. A fast system clock samples the active-low row strobe, column strobe and write enable, and an 11-bit address bus. Each memory cycle is then classified as one of the following:

- a read
- an early write
- a refresh that latches a row and never opens a column
- a refresh taken from the internal row counter when the column strobe leads
- an entry into the parallel test mode

A small parameterized bit array stands in for the cell storage. It is large enough for an exhaustive sweep.

Three address bits pick one bit out of a group of eight: the top row bit, the top column bit and the lowest column bit. A latched test mode treats each group of eight as one unit. A write in test mode fills the whole group. A read in test mode returns a single level that says whether all eight bits agree. The cycle type, the test-mode flag and the refresh counter are brought out, so that a bench can compare the decode against its own expectation.

Top module: `dram_ctl_model`

## Requirements
- R1: After a clock edge with `rst_n` low, `cyc_type` is 0 (idle), `test_mode` is 0, `refresh_row` is 0 and `data_oe` is 0.
- R2: When `cas_n` is low at the clock where `ras_n` is first seen low and `we_n` is high, `refresh_row` rises by exactly one (wrapping), `cyc_type` becomes 4 and `test_mode` is cleared. The counter changes at no other time.
- R3: When `cas_n` and `we_n` are both low at the clock where `ras_n` is first seen low, `test_mode` becomes 1, `cyc_type` becomes 5 and `refresh_row` still rises by one. The flag then holds through any number of reads and writes.
- R4: When `ras_n` goes low with `cas_n` high and returns high with no `cas_n` fall in between, `cyc_type` becomes 3 at the clock where `ras_n` is seen high. That same clock clears `test_mode`. `refresh_row` does not change and `data_oe` stays 0.
- R5: A `cas_n` fall inside an open row with `we_n` high is a read. One clock later `data_oe` is 1, `cyc_type` is 1 and `data_out` holds the addressed cell. `data_oe` returns to 0 one clock after `cas_n` is seen high. A cell is addressed by group {row[1:0], col[2:1]} and by bit {row[10], col[10], col[0]}, where row bits are latched at the `ras_n` fall and column bits at the `cas_n` fall. Address bits 9..2 of the row and 9..3 of the column are not decoded at the default sizes.
- R6: A `cas_n` fall inside an open row with `we_n` low is an early write. It stores `din` in the addressed cell, `cyc_type` becomes 2 and `data_oe` stays 0.
- R7: Several `cas_n` pulses within one `ras_n` low period reuse the latched row, and each one performs its own read or write.
- R8: In test mode a write stores `din` into all eight bits of the addressed group. A read returns 1 when the eight bits of the group are all equal and 0 when any of them differs.
- R9: In test mode the values of row[10], col[10] and col[0] have no effect on which group is compared or written.
- R10: When `cas_n` stays low after a read while `ras_n` rises and falls again, a counter refresh happens as in R2, while `data_oe` stays 1 and `data_out` keeps the read value until `cas_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 1 | Write data |
| data_out | output | 1 | Read data or test-mode pass level |
| data_oe | output | 1 | High while the model drives data (0 means high impedance) |
| cyc_type | output | 3 | Last decoded cycle: 0 idle, 1 read, 2 write, 3 row-only refresh, 4 counter refresh, 5 test entry |
| test_mode | output | 1 | Latched parallel test mode flag |
| refresh_row | output | 10 | Internal refresh row counter |

## Verification
The kinds of wrong internal state are each visible at the ports within a few clocks.

- A wrong latched row or a wrong bit-select mapping gives a wrong `data_out` on the very next read of the cell concerned. The exhaustive write-then-read sweep over every cell exposes such a fault within one row's page of reads.
- A test-mode flag that sets, clears or sticks wrongly changes `test_mode` one clock after the deciding strobe edge. It also flips the meaning of the following reads, from a cell value to a group-match level.
- A refresh counter that steps at the wrong time shows up in `refresh_row` one clock after the `ras_n` fall.
- An output enable that is not held through a hidden refresh drops `data_oe` while `cas_n` is still low.

// File: rtl/dsd_pkg.sv
// Shared types for the DRAM strobe decoder model.
// Assumes: strobes are sampled by a clock fast enough to see every level.
package dsd_pkg;
    // Decoded cycle kinds, visible on cyc_type.
    typedef enum logic [2:0] {
        CYC_IDLE       = 3'd0,
        CYC_READ       = 3'd1,
        CYC_WRITE      = 3'd2,
        CYC_ROW_ONLY   = 3'd3,
        CYC_CTR_REF    = 3'd4,
        CYC_TEST_ENTRY = 3'd5
    } cyc_e;

    // Phase of the current row-strobe period.
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_ROW_OPEN = 2'd1,
        PH_REF_HOLD = 2'd2
    } phase_e;
endpackage

// File: rtl/dsd_strobe_edges.sv
// Strobe edge detector.
// Registers the previous level of each strobe and flags the edges seen at
// this clock. Assumes: strobes are synchronous to clk (bench/model use).
module dsd_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic cas_rise
);
    logic ras_q;
    logic cas_q;

    // Hold last sampled strobe levels; inactive (high) after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_q & ~cas_n;
    assign cas_rise = ~cas_q & cas_n;
endmodule

// File: rtl/dsd_refresh_ctr.sv
// Internal refresh row counter.
// Steps by one, wrapping, on each counter-refresh request.
// Assumes: inc is a single-cycle pulse per refresh.
module dsd_refresh_ctr #(
    parameter int CTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CTR_W-1:0] count
);
    // Advance the row pointer on each refresh request.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_ctr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> count == CTR_W'($past(count) + 1'b1));
    assert_ctr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/dsd_cell_array.sv
// Small stand-in cell array organised as groups of eight bits.
// Group index comes from low row/column bits; the bit within the group from
// the top row bit, the top column bit and column bit 0. In test mode a write
// fills the whole group, and rd_match reports whether the group is uniform.
// Assumes: row/col are stable during the write clock.
module dsd_cell_array #(
    parameter int ADDR_W   = 11,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic              din,
    output logic              rd_bit,
    output logic              rd_match
);
    localparam int GRP_W  = ROW_BITS + COL_BITS;
    localparam int GROUPS = 1 << GRP_W;
    localparam int SUB_W  = 3;
    localparam int SUB_N  = 1 << SUB_W;

    logic [SUB_N-1:0] mem [GROUPS];
    logic [GRP_W-1:0] gidx;
    logic [SUB_W-1:0] sel;
    logic [SUB_N-1:0] grp;
    logic             unused_addr_bits;

    assign gidx = {row[ROW_BITS-1:0], col[COL_BITS:1]};
    assign sel  = {row[ADDR_W-1], col[ADDR_W-1], col[0]};
    assign grp  = mem[gidx];
    assign rd_bit   = grp[sel];
    assign rd_match = (&grp) | ~(|grp);
    assign unused_addr_bits = ^{row[ADDR_W-2:ROW_BITS], col[ADDR_W-2:COL_BITS+1]};

    // Clear the array on reset; store one bit or a whole group on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < GROUPS; g++) mem[g] <= '0;
        end else if (wr_en) begin
            if (wr_all) mem[gidx]      <= {SUB_N{din}};
            else        mem[gidx][sel] <= din;
        end
    end

    assert_group_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all) |=> rd_match);
endmodule

// File: rtl/dsd_cycle_ctrl.sv
// Cycle decoder and test-mode latch.
// Classifies each strobe sequence, latches row/column addresses, drives the
// data output and its enable, and requests counter refreshes.
// Assumes: edge flags come from dsd_strobe_edges at the same clock.
module dsd_cycle_ctrl
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    input  logic              cas_rise,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_bit,
    input  logic              rd_match,
    output logic [ADDR_W-1:0] row_q,
    output logic              wr_en,
    output logic              wr_all,
    output logic              ref_inc,
    output logic              test_mode,
    output cyc_e              cyc_q,
    output logic              dout,
    output logic              dout_oe
);
    phase_e phase;
    logic   cas_seen;
    logic   access;

    assign ref_inc = ras_fall & ~cas_n;
    assign access  = (phase == PH_ROW_OPEN) & cas_fall;
    assign wr_en   = access & ~we_n;
    assign wr_all  = test_mode;

    // Track the row-strobe phase and latch the row address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            row_q    <= '0;
            cas_seen <= 1'b0;
        end else if (ras_fall) begin
            if (!cas_n) begin
                phase <= PH_REF_HOLD;
            end else begin
                phase    <= PH_ROW_OPEN;
                row_q    <= addr;
                cas_seen <= 1'b0;
            end
        end else if (ras_rise) begin
            phase <= PH_IDLE;
        end else if (access) begin
            cas_seen <= 1'b1;
        end
    end

    // Decode cycle type and maintain the latched test-mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q     <= CYC_IDLE;
            test_mode <= 1'b0;
        end else if (ref_inc) begin
            test_mode <= ~we_n;
            cyc_q     <= we_n ? CYC_CTR_REF : CYC_TEST_ENTRY;
        end else if (ras_rise && phase == PH_ROW_OPEN && !cas_seen) begin
            test_mode <= 1'b0;
            cyc_q     <= CYC_ROW_ONLY;
        end else if (access) begin
            cyc_q <= we_n ? CYC_READ : CYC_WRITE;
        end
    end

    // Drive read data at a read access; release the output when CAS rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (access && we_n) begin
            dout    <= test_mode ? rd_match : rd_bit;
            dout_oe <= 1'b1;
        end else if (cas_rise) begin
            dout_oe <= 1'b0;
        end
    end

    assert_drive_only_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(we_n));
    assert_test_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> $past(!we_n && !cas_n && ras_fall));
    assert_test_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> $past(ras_fall || ras_rise));
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe)) |-> $stable(dout));
    assert_refresh_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_inc |=> (cyc_q == CYC_CTR_REF || cyc_q == CYC_TEST_ENTRY));
endmodule

// File: rtl/dram_ctl_model.sv
// Top of the DRAM strobe decoder model.
// Wires the edge detector, cycle decoder, refresh counter and cell array.
// Assumes: all strobe and address inputs are synchronous to clk.
module dram_ctl_model
    import dsd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int CTR_W    = 10,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              data_out,
    output logic              data_oe,
    output logic [2:0]        cyc_type,
    output logic              test_mode,
    output logic [CTR_W-1:0]  refresh_row
);
    logic              ras_fall, ras_rise, cas_fall, cas_rise;
    logic [ADDR_W-1:0] row_q;
    logic              wr_en, wr_all, ref_inc;
    logic              rd_bit, rd_match;
    cyc_e              cyc_q;

    dsd_strobe_edges edges_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise)
    );

    dsd_cycle_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .cas_rise(cas_rise),
        .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .rd_bit(rd_bit), .rd_match(rd_match),
        .row_q(row_q), .wr_en(wr_en), .wr_all(wr_all), .ref_inc(ref_inc),
        .test_mode(test_mode), .cyc_q(cyc_q),
        .dout(data_out), .dout_oe(data_oe)
    );

    dsd_refresh_ctr #(.CTR_W(CTR_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .inc(ref_inc), .count(refresh_row)
    );

    dsd_cell_array #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) array_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_all(wr_all),
        .row(row_q), .col(addr), .din(din),
        .rd_bit(rd_bit), .rd_match(rd_match)
    );

    assign cyc_type = cyc_q;
endmodule

// File: tb/dram_ctl_model_tb_top.sv
module dram_ctl_model_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [10:0] addr = '0;
    logic        data_out, data_oe, test_mode;
    logic [2:0]  cyc_type;
    logic [9:0]  refresh_row;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    logic refm [16][8];

    always #2.5 clk = ~clk;

    dram_ctl_model dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .data_out(data_out), .data_oe(data_oe),
        .cyc_type(cyc_type), .test_mode(test_mode), .refresh_row(refresh_row)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int gidx(input int r, input int c);
        return ((r & 3) << 2) | ((c >> 1) & 3);
    endfunction
    function automatic int sub(input int r, input int c);
        return (((r >> 2) & 1) << 2) | (((c >> 3) & 1) << 1) | (c & 1);
    endfunction
    function automatic logic [10:0] rowaddr(input int r);
        logic [7:0] mid = 8'(r * 37);
        return {1'(r >> 2), mid, 2'(r)};
    endfunction
    function automatic logic [10:0] coladdr(input int c);
        logic [6:0] mid = 7'(c * 11);
        return {1'(c >> 3), mid, 2'(c >> 1), 1'(c)};
    endfunction
    function automatic logic pattern(input int g, input int s);
        logic b = 1'((g >> 1) & 1);
        if ((g & 1) && s == 5) b = ~b;
        return b;
    endfunction
    function automatic int all_eq(input int g);
        int ones = 0;
        for (int s = 0; s < 8; s++) ones += refm[g][s];
        return (ones == 0 || ones == 8) ? 1 : 0;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ras_down(input int r);
        addr = rowaddr(r); ras_n = 1'b0; step();
    endtask
    task automatic ras_up();
        ras_n = 1'b1; step();
    endtask
    task automatic cas_write(input int r, input int c, input logic d, input logic tm);
        addr = coladdr(c); we_n = 1'b0; din = d; cas_n = 1'b0; step();
        cas_n = 1'b1; we_n = 1'b1; step();
        if (tm) for (int s = 0; s < 8; s++) refm[gidx(r, c)][s] = d;
        else refm[gidx(r, c)][sub(r, c)] = d;
    endtask
    task automatic cas_read(input int c, input int exp, input string tag);
        addr = coladdr(c); we_n = 1'b1; cas_n = 1'b0; step();
        chk({tag, " data_oe"}, data_oe, 1);
        chk({tag, " data"}, data_out, exp);
        cas_n = 1'b1; step();
        chk({tag, " release"}, data_oe, 0);
    endtask
    task automatic ctr_refresh(input logic we);
        cas_n = 1'b0; we_n = we; step();
        ras_n = 1'b0; step();
        exp_cnt = (exp_cnt + 1) % 1024;
        ras_n = 1'b1; step();
        cas_n = 1'b1; we_n = 1'b1; step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 cyc_type", cyc_type, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 refresh_row", refresh_row, 0);
        chk("R1 data_oe", data_oe, 0);
        rst_n = 1'b1; step();

        // R6/R7: write every cell, one page per row
        for (int r = 0; r < 8; r++) begin
            ras_down(r);
            for (int c = 0; c < 16; c++) begin
                cas_write(r, c, pattern(gidx(r, c), sub(r, c)), 1'b0);
                if (c == 0) begin
                    chk("R6 cyc write", cyc_type, 2);
                    chk("R6 no drive", data_oe, 0);
                end
            end
            ras_up();
            chk("R7 no row-only after page", cyc_type, 2);
        end
        // R5/R7: page-mode readback of every cell
        for (int r = 0; r < 8; r++) begin
            ras_down(r);
            for (int c = 0; c < 16; c++) begin
                cas_read(c, refm[gidx(r, c)][sub(r, c)], "R5 R7 read");
                if (c == 0) chk("R5 cyc read", cyc_type, 1);
            end
            ras_up();
        end
        // R4: row-only refresh
        ras_down(3); step(); step();
        chk("R4 oe low", data_oe, 0);
        ras_up();
        chk("R4 cyc", cyc_type, 3);
        chk("R4 counter unchanged", refresh_row, exp_cnt);
        // R2: counter refreshes
        for (int k = 0; k < 3; k++) begin
            ctr_refresh(1'b1);
            chk("R2 counter", refresh_row, exp_cnt);
            chk("R2 cyc", cyc_type, 4);
            chk("R2 test_mode", test_mode, 0);
        end
        // R3: test entry
        ctr_refresh(1'b0);
        chk("R3 test_mode", test_mode, 1);
        chk("R3 cyc", cyc_type, 5);
        chk("R3 counter", refresh_row, exp_cnt);
        // R8/R9: every group through all eight ignored-bit variants
        for (int r = 0; r < 8; r++) begin
            ras_down(r);
            for (int c = 0; c < 16; c++) cas_read(c, all_eq(gidx(r, c)), "R8 R9 test read");
            ras_up();
        end
        chk("R3 flag held", test_mode, 1);
        // R8: group fill in test mode, checked via a different sub-address
        ras_down(0); cas_write(0, 2, 1'b1, 1'b1); ras_up();
        ras_down(4); cas_read(11, 1, "R9 test read after fill"); ras_up();
        chk("R3 flag held after write", test_mode, 1);
        ctr_refresh(1'b1);
        chk("R2 exit test", test_mode, 0);
        for (int r = 0; r < 8; r += 4) begin
            ras_down(r);
            cas_read(2, 1, "R8 filled bit"); cas_read(3, 1, "R8 filled bit");
            cas_read(10, 1, "R8 filled bit"); cas_read(11, 1, "R8 filled bit");
            ras_up();
        end
        ras_down(0); cas_write(0, 3, 1'b0, 1'b0); ras_up();
        ctr_refresh(1'b0);
        chk("R3 reentry", test_mode, 1);
        ras_down(4); cas_read(10, 0, "R8 mismatch"); ras_up();
        ras_down(1); step(); ras_up();
        chk("R4 exit test", test_mode, 0);
        chk("R4 cyc exit", cyc_type, 3);
        // R10: hidden refresh
        ras_down(0);
        addr = coladdr(2); we_n = 1'b1; cas_n = 1'b0; step();
        chk("R10 read data", data_out, 1);
        ras_n = 1'b1; step();
        ras_n = 1'b0; step();
        exp_cnt = (exp_cnt + 1) % 1024;
        chk("R10 oe held", data_oe, 1);
        chk("R10 data held", data_out, 1);
        chk("R10 counter", refresh_row, exp_cnt);
        chk("R10 cyc", cyc_type, 4);
        ras_n = 1'b1; step();
        chk("R10 oe still held", data_oe, 1);
        cas_n = 1'b1; step();
        chk("R10 release", data_oe, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule